// File: doc/BRIEF.md
# DDS Serial Register Access Engine

This block is the serial master that reads and writes the control registers of a direct digital synthesizer. A single request on the user side (direction, length, register address and up to 64 bits of write data) becomes one framed transaction on a four-wire serial bus. The frame starts with an 8-bit instruction byte, and the data phase follows it under the same chip-select assertion. The instruction byte carries a direction flag and the register address. A write sends one 32-bit word, or two 32-bit words with the upper one first. A read clocks 32 bits back in from the device.

The serial clock is the system clock divided by an even parameter. It idles low. The outgoing line changes on falling serial-clock edges, and the incoming line is sampled on rising edges. After the last bit the engine releases chip select and keeps it released for one full serial-clock period before it reports completion. A further request cannot therefore start a frame too early. While the engine is busy, new requests are dropped.

Top module: `dds_spi_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, cs_n is 1, sclk is 0, busy is 0, done is 0 and rd_data is 0.
- R2: The first 8 bits shifted out are the instruction byte {req_read, 2'b00, req_addr[4:0]} (ADDR_W=5), MSB first, so bit 7 is 1 for a read and 0 for a write.
- R3: A 32-bit write (req_read=0, req_wide=0) gives exactly 40 rising sclk edges under one low period of cs_n: the instruction byte, then req_wdata[31:0] MSB first, with no gap.
- R4: A 64-bit write (req_read=0, req_wide=1) gives exactly 72 rising sclk edges: the instruction byte, then req_wdata[63:32], then req_wdata[31:0], each MSB first.
- R5: A read (req_read=1, req_wide ignored) gives 40 rising edges and drives mosi low after the instruction byte. rd_data holds the last 32 miso samples, the first sampled bit in rd_data[31]. rd_data is valid with done and is left unchanged by writes.
- R6: sclk is low whenever no frame is in progress. Inside a frame its rising edges are exactly DIV system clocks apart.
- R7: mosi changes only in the cycle where sclk falls or where cs_n falls.
- R8: sclk is never high while cs_n is high, and between two frames cs_n stays high for at least DIV system clocks.
- R9: busy goes high in the cycle after a request is accepted. done is a one-cycle pulse in the cycle where busy falls.
- R10: A request made while busy is ignored: the current frame is unchanged, no extra frame follows and busy falls once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 64 | Write data; only [31:0] used for 32-bit writes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Data from the last completed read |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with DIV=4 and ADDR_W=5, so each half serial period lasts two system clocks. At this setting the divider counter, the lead-in half period and the closing gap all run through real counts and are not short cuts. It sweeps every register address from 0x00 to 0x16 in all three transaction kinds, using data patterns derived from the address. A bus model captures each frame bit by bit and returns read patterns on miso. Monitors measure the serial-clock period, when mosi changes, and the chip-select gap, including back-to-back requests issued in the very cycle done appears.

// File: rtl/dds_spi_pkg.sv
// Package: shared types and frame arithmetic for the DDS serial engine.
// Assumes frames are one 8-bit instruction plus 32 or 64 data bits.
package dds_spi_pkg;

    localparam int INSTR_BITS = 8;
    localparam int WORD_BITS  = 32;
    localparam int FRAME_MAX  = INSTR_BITS + 2 * WORD_BITS;
    localparam int CNT_W      = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_RUN,
        SEQ_GAP
    } seq_t;

    // Number of serial bits in a frame of the given kind.
    function automatic logic [CNT_W-1:0] frame_len(input logic rd, input logic wide);
        frame_len = (wide && !rd) ? CNT_W'(FRAME_MAX) : CNT_W'(INSTR_BITS + WORD_BITS);
    endfunction

endpackage

// File: rtl/dds_spi_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every HALF system clocks while run is high; restarts when run drops.
// Assumes HALF >= 1.
module dds_spi_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF == 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt;

            // Count system clocks within one half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == CW'(HALF - 1));

            assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dds_spi_shifter.sv
// Module: frame shift register and read-data capture.
// Loads the full outgoing frame on load, shifts it left on shift (falling edge),
// collects miso on sample (rising edge), and copies the last 32 samples on capture.
// Assumes ADDR_W <= 7 so the address fits below the direction bit.
module dds_spi_shifter
    import dds_spi_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic                 sample,
    input  logic                 capture,
    input  logic                 req_read,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [63:0]          req_wdata,
    input  logic                 miso,
    output logic                 mosi,
    output logic [WORD_BITS-1:0] rd_data
);

    logic [FRAME_MAX-1:0]  tx_q;
    logic [FRAME_MAX-1:0]  frame_d;
    logic [WORD_BITS-1:0]  rx_q;
    logic [INSTR_BITS-1:0] instr;

    // Instruction byte: direction flag on top, address zero-extended below it.
    assign instr = {req_read, 7'(req_addr)};

    // Assemble the outgoing frame for the requested kind.
    always_comb begin
        if (req_read) begin
            frame_d = {instr, 64'd0};
        end else if (req_wide) begin
            frame_d = {instr, req_wdata[63:32], req_wdata[31:0]};
        end else begin
            frame_d = {instr, req_wdata[31:0], 32'd0};
        end
    end

    // Outgoing shift register, MSB drives the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= frame_d;
        end else if (shift) begin
            tx_q <= {tx_q[FRAME_MAX-2:0], 1'b0};
        end
    end

    // Incoming shift register, keeps the most recent 32 samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_q[WORD_BITS-2:0], miso};
        end
    end

    // Read result register, updated only at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= rx_q;
        end
    end

    assign mosi = tx_q[FRAME_MAX-1];

    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_data));

endmodule

// File: rtl/dds_spi_ctrl.sv
// Module: transaction sequencer.
// Accepts a request when idle, asserts chip select, drives the serial clock
// from divider ticks, counts rising edges against the frame length, then holds
// chip select released for two half periods before signalling done.
module dds_spi_ctrl
    import dds_spi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    input  logic req_wide,
    input  logic tick,
    output logic run,
    output logic load,
    output logic shift,
    output logic sample,
    output logic capture,
    output logic busy,
    output logic done,
    output logic cs_n,
    output logic sclk
);

    seq_t             state;
    logic [CNT_W-1:0] rises;
    logic [CNT_W-1:0] total;
    logic             is_read;
    logic             gap_half;

    assign run  = (state != SEQ_IDLE);
    assign busy = run;

    // Strobes to the datapath for this cycle.
    always_comb begin
        load    = (state == SEQ_IDLE) && req_valid;
        sample  = tick && ((state == SEQ_LEAD) || ((state == SEQ_RUN) && !sclk));
        shift   = tick && (state == SEQ_RUN) && sclk && (rises != total);
        capture = tick && (state == SEQ_GAP) && gap_half && is_read;
    end

    // Sequencer state, serial clock, chip select and edge counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            rises    <= '0;
            total    <= '0;
            is_read  <= 1'b0;
            gap_half <= 1'b0;
            cs_n     <= 1'b1;
            sclk     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        state   <= SEQ_LEAD;
                        cs_n    <= 1'b0;
                        rises   <= '0;
                        total   <= frame_len(req_read, req_wide);
                        is_read <= req_read;
                    end
                end
                SEQ_LEAD: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rises <= rises + 1'b1;
                        state <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (tick) begin
                        if (sclk) begin
                            sclk <= 1'b0;
                            if (rises == total) begin
                                cs_n     <= 1'b1;
                                gap_half <= 1'b0;
                                state    <= SEQ_GAP;
                            end
                        end else begin
                            sclk  <= 1'b1;
                            rises <= rises + 1'b1;
                        end
                    end
                end
                SEQ_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= CNT_W'(FRAME_MAX));

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !tick) |=> ($stable(cs_n) && $stable(rises)));

endmodule

// File: rtl/dds_spi_engine.sv
// Module: top of the DDS serial register access engine.
// Joins the half-period divider, sequencer and shift datapath.
// Assumes DIV is even and at least 2; ADDR_W at most 7.
module dds_spi_engine
    import dds_spi_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam int HALF = DIV / 2;

    logic run, tick, load, shift, sample, capture;

    dds_spi_clkdiv #(.HALF(HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    dds_spi_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_wide  (req_wide),
        .tick      (tick),
        .run       (run),
        .load      (load),
        .shift     (shift),
        .sample    (sample),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .cs_n      (cs_n),
        .sclk      (sclk)
    );

    dds_spi_shifter #(.ADDR_W(ADDR_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (shift),
        .sample    (sample),
        .capture   (capture),
        .req_read  (req_read),
        .req_wide  (req_wide),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .miso      (miso),
        .mosi      (mosi),
        .rd_data   (rd_data)
    );

    assert_cs_sclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($fell(sclk) || $fell(cs_n)));

endmodule

// File: tb/tb_dds_spi_engine.sv
module tb_dds_spi_engine;

    localparam int DIV    = 4;
    localparam int ADDR_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0, req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic busy, done, cs_n, sclk, mosi;
    logic miso = 1'b0;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dds_spi_engine #(.DIV(DIV), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .miso(miso)
    );

    // Device model: capture mosi on rising sclk, present read bits after falling sclk.
    int rises = 0;
    logic [71:0] cap = '0;
    logic [31:0] rpat = '0;
    always @(posedge sclk) if (!cs_n) begin
        cap = {cap[70:0], mosi};
        rises = rises + 1;
    end
    always @(negedge sclk) miso = (rises >= 8 && rises < 40) ? rpat[39 - rises] : 1'b0;

    // Line monitors sampled on the falling system clock.
    int err_period = 0, err_mosi = 0, err_gap = 0, err_cs = 0, cs_falls = 0;
    int per = 0, hi_cnt = 0;
    bit seen_rise = 0, seen_frame = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            per = per + 1;
            if (sclk && !p_sclk) begin
                if (seen_rise && per != DIV) err_period++;
                seen_rise = 1; per = 0;
            end
            if (cs_n && !p_cs) seen_rise = 0;
            if (cs_n && sclk) err_cs++;
            if (mosi != p_mosi && !(p_sclk && !sclk) && !(p_cs && !cs_n)) err_mosi++;
            if (!cs_n && p_cs) begin
                cs_falls++;
                if (seen_frame && hi_cnt < DIV) err_gap++;
                seen_frame = 1;
            end
            hi_cnt = cs_n ? hi_cnt + 1 : 0;
            p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one transaction and check the frame and result against the requirements.
    logic [31:0] last_rd = '0;
    task automatic txn(input bit rd, input bit wide, input logic [4:0] addr,
                       input logic [63:0] wd, input logic [31:0] pat);
        logic [7:0] instr;
        int n;
        while (busy) @(negedge clk);
        cap = '0; rises = 0; rpat = pat; miso = 1'b0;
        req_valid = 1; req_read = rd; req_wide = wide; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1'b1, "R9 busy after accept", 72'(busy), 72'd1);
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R9 busy low with done", 72'(busy), 72'd0);
        instr = {rd, 2'b00, addr};
        n = (wide && !rd) ? 72 : 40;
        if (rd) begin
            chk(rises == 40, "R5 read edge count", 72'(rises), 72'd40);
            chk(cap[39:0] == {instr, 32'd0}, "R5 R2 read frame", 72'(cap[39:0]), 72'({instr, 32'd0}));
            chk(rd_data == pat, "R5 read data", 72'(rd_data), 72'(pat));
            last_rd = pat;
        end else if (wide) begin
            chk(rises == 72, "R4 wide edge count", 72'(rises), 72'd72);
            chk(cap == {instr, wd}, "R4 R2 wide frame", cap, {instr, wd});
            chk(rd_data == last_rd, "R5 rd_data held on write", 72'(rd_data), 72'(last_rd));
        end else begin
            chk(rises == 32'(n), "R3 narrow edge count", 72'(rises), 72'(n));
            chk(cap[39:0] == {instr, wd[31:0]}, "R3 R2 narrow frame", 72'(cap[39:0]), 72'({instr, wd[31:0]}));
        end
    endtask

    initial begin : wdog
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk({cs_n, sclk, busy, done} == 4'b1000, "R1 reset outputs", 72'({cs_n, sclk, busy, done}), 72'h8);
        rst_n = 1;
        @(negedge clk);
        chk({cs_n, sclk, busy, done} == 4'b1000, "R1 after release", 72'({cs_n, sclk, busy, done}), 72'h8);
        chk(rd_data == 32'd0, "R1 rd_data", 72'(rd_data), 72'd0);

        for (int a = 0; a <= 22; a++) begin
            logic [31:0] d;
            d = 32'h1234_5678 ^ (32'(a) * 32'h0101_0101);
            txn(0, 0, 5'(a), {32'hDEAD_BEEF, d}, 32'd0);
            txn(1, 0, 5'(a), 64'd0, ~d);
            txn(0, 1, 5'(a), {d, ~d ^ 32'(a)}, 32'd0);
            txn(1, 1, 5'(a), 64'hFFFF_FFFF_FFFF_FFFF, {d[15:0], d[31:16]});
        end

        // R10: request during a frame is dropped.
        begin
            int f0;
            while (busy) @(negedge clk);
            f0 = cs_falls;
            cap = '0; rises = 0;
            req_valid = 1; req_read = 0; req_wide = 0; req_addr = 5'h03; req_wdata = 64'h0000_0000_A5C3_0F96;
            @(negedge clk);
            req_valid = 0;
            repeat (20) @(negedge clk);
            req_valid = 1; req_read = 1; req_wide = 1; req_addr = 5'h09; req_wdata = '1;
            @(negedge clk);
            req_valid = 0;
            while (!done) @(negedge clk);
            repeat (30) @(negedge clk);
            chk(cap[39:0] == {8'h03, 32'hA5C3_0F96}, "R10 frame unchanged", 72'(cap[39:0]), 72'({8'h03, 32'hA5C3_0F96}));
            chk(cs_falls == f0 + 1, "R10 single frame", 72'(cs_falls), 72'(f0 + 1));
            chk(busy == 1'b0, "R10 stays idle", 72'(busy), 72'd0);
            chk(rd_data == last_rd, "R10 rd_data untouched", 72'(rd_data), 72'(last_rd));
        end

        chk(err_period == 0, "R6 sclk period", 72'(err_period), 72'd0);
        chk(err_mosi == 0, "R7 mosi edges", 72'(err_mosi), 72'd0);
        chk(err_gap == 0, "R8 cs gap", 72'(err_gap), 72'd0);
        chk(err_cs == 0, "R8 sclk under cs high", 72'(err_cs), 72'd0);
        chk(cs_falls == 93, "R3 frame count", 72'(cs_falls), 72'd93);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule